// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is an SMBus target that holds a small bank of 8-bit configuration registers. A host reaches the bank only through indexed block transfers. To write, the host addresses the target, sends a starting register index, then a byte count, then that many data bytes. The bytes land in consecutive registers.

To read, the host sends the address with the write bit and the index, then issues a repeated start and the address with the read bit. The target answers with a count byte, then with register contents from the chosen index onward. The count byte is taken from the highest register in the bank, so the host can program it.

SCL and SDA are sampled on the system clock. Each line passes through a synchroniser and a glitch filter before start and stop conditions are detected. The target drives SDA through an open-drain enable, and its 7-bit address comes from strap inputs. Every register is visible at all times on a flat parallel output.

Top module: `smbr_target`

## Requirements
- R1: After reset every register reads 0x00, except the top register (index NREGS-1 = 8, the read-count register), which reads 0x08. The SDA pull-down is released.
- R2: An address byte whose upper 7 bits differ from `addr_sel` is not acknowledged, and the transaction that follows leaves every register unchanged.
- R3: In a write to the matching address, the target acknowledges the address byte, the index byte, the count byte and each data byte within the count. Data byte j is stored in register N+j. The target never pulls SDA low while it is receiving bits.
- R4: A write data byte beyond the byte count is not acknowledged and not stored.
- R5: After the register at index NREGS-1 the index wraps to 0, for writes and for reads. A starting index of NREGS or above makes its first write a discarded but acknowledged byte, and its first read returns 0x00. The next access goes to index 0.
- R6: After a repeated start and the read address, the target sends the value of the read-count register first. It then sends the registers from the written index onward, most significant bit first, for as long as the host acknowledges.
- R7: After the host answers a byte with a not-acknowledge, the target releases SDA. It ignores further clocking until the next start condition.
- R8: A start condition in the middle of a byte abandons the current transfer, keeps the register writes already completed, and begins a new address phase.
- R9: A pulse on SDA or SCL that lasts fewer than FILT (default 3) system clocks has no effect on the transfer.
- R10: The SDA pull-down changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sampled from the pad |
| sda_in | input | 1 | Bus data line as sampled from the pad (wired-AND level) |
| addr_sel | input | 7 | Target address from strap pins |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_out | output | NREGS*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
The checks assume that each SCL phase lasts many system clocks longer than the synchroniser and filter delay added together. They also assume that the host moves SDA only while SCL is low, apart from start and stop conditions. The bench host keeps SCL high and low for 20 clocks each. It changes its data 10 clocks after each falling edge of SCL, so every edge the target makes settles well before the next SCL rise. The only deliberate breach of these limits is a single-clock dip on SDA while SCL is high, used to exercise the filter.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_RACK
    } bit_st_t;

    typedef enum logic [2:0] {
        P_ADDR,
        P_INDEX,
        P_COUNT,
        P_DATA,
        P_TXCNT,
        P_TXDAT
    } phase_t;

    function automatic logic [7:0] reset_value(int idx, int cnt_idx);
        return (idx == cnt_idx) ? 8'(cnt_idx) : 8'h00;
    endfunction

    function automatic logic [7:0] step_index(logic [7:0] i, logic [7:0] last);
        return (i >= last) ? 8'h00 : i + 8'h01;
    endfunction

endpackage

// File: rtl/smbr_deglitch.sv
module smbr_deglitch #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            q    <= 1'b1;
            cnt  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] == q) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT - 1)) begin
                q   <= sync[1];
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbr_bus_front.sv
module smbr_bus_front #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] raw, filt;
    logic       scl_p, sda_p;

    assign raw = {scl_in, sda_in};

    for (genvar k = 0; k < 2; k++) begin : g_line
        smbr_deglitch #(.FILT(FILT)) u_dg (
            .clk (clk),
            .rst (rst),
            .din (raw[k]),
            .q   (filt[k])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile #(
    parameter int NREGS = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [7:0]         widx,
    input  logic [7:0]         wdata,
    input  logic [7:0]         ridx,
    output logic [7:0]         rdata,
    output logic [NREGS*8-1:0] regs_flat
);
    import smbr_pkg::*;
    localparam int CNT_IDX = NREGS - 1;

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[k*8 +: 8] <= reset_value(k, CNT_IDX);
            else if (we && widx == 8'(k))
                regs_flat[k*8 +: 8] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NREGS; k++)
            if (ridx == 8'(k)) rdata = regs_flat[k*8 +: 8];
    end

    // R5
    widx_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (widx < 8'(NREGS)));
endmodule

// File: rtl/smbr_target.sv
module smbr_target #(
    parameter int NREGS = 9,
    parameter int FILT  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [6:0]         addr_sel,
    output logic               sda_drive_low,
    output logic [NREGS*8-1:0] regs_out
);
    import smbr_pkg::*;
    localparam int         CNT_IDX = NREGS - 1;
    localparam logic [7:0] LAST    = 8'(NREGS - 1);

    logic       scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    bit_st_t    st;
    phase_t     ph;
    logic [3:0] bitcnt;
    logic [7:0] shreg, ptr, remain, rdata, cnt_reg;
    logic       host_ack, sda_low, we, byte_done;

    smbr_bus_front #(.FILT(FILT)) u_front (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign byte_done = (st == S_RX) && scl_fall && (bitcnt == 4'd8)
                       && !start_ev && !stop_ev;
    assign we        = byte_done && (ph == P_DATA) && (remain != 8'h00)
                       && (ptr < 8'(NREGS));

    smbr_regfile #(.NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .widx      (ptr),
        .wdata     (shreg),
        .ridx      (ptr),
        .rdata     (rdata),
        .regs_flat (regs_out)
    );

    assign cnt_reg       = regs_out[CNT_IDX*8 +: 8];
    assign sda_drive_low = sda_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ph       <= P_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            remain   <= '0;
            host_ack <= 1'b0;
            sda_low  <= 1'b0;
        end else if (start_ev) begin
            st      <= S_RX;
            ph      <= P_ADDR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else if (stop_ev) begin
            st      <= S_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (st)
                S_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        st     <= S_ACK;
                        case (ph)
                            P_ADDR: begin
                                if (shreg[7:1] == addr_sel) begin
                                    sda_low <= 1'b1;
                                    ph      <= shreg[0] ? P_TXCNT : P_INDEX;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            P_INDEX: begin
                                ptr     <= shreg;
                                sda_low <= 1'b1;
                                ph      <= P_COUNT;
                            end
                            P_COUNT: begin
                                remain  <= shreg;
                                sda_low <= 1'b1;
                                ph      <= P_DATA;
                            end
                            P_DATA: begin
                                if (remain != 8'h00) begin
                                    remain  <= remain - 8'h01;
                                    ptr     <= step_index(ptr, LAST);
                                    sda_low <= 1'b1;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            default: st <= S_IDLE;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (ph == P_TXCNT) begin
                            shreg   <= cnt_reg;
                            sda_low <= ~cnt_reg[7];
                            ph      <= P_TXDAT;
                            st      <= S_TX;
                        end else begin
                            sda_low <= 1'b0;
                            st      <= S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_low  <= 1'b0;
                            host_ack <= 1'b0;
                            st       <= S_RACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_f;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            shreg   <= rdata;
                            sda_low <= ~rdata[7];
                            ptr     <= step_index(ptr, LAST);
                            bitcnt  <= '0;
                            st      <= S_TX;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !sda_drive_low);

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_f);

    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (st == S_RX && ph == P_ADDR && bitcnt == 4'd0));

    // R3
    rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_RX) |-> !sda_drive_low);
endmodule

// File: tb/sim_smbr_target.sv
module sim_smbr_target;
    localparam int         NREGS = 9;
    localparam int         Q     = 10;
    localparam logic [6:0] STRAP = 7'h6A;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               scl = 1'b1;
    logic               host_sda = 1'b1;
    logic               sda_line;
    logic               sda_drive_low;
    logic [NREGS*8-1:0] regs_out;

    int   checks = 0;
    int   errors = 0;
    int   bad_edges = 0;
    logic low_seen;
    logic done = 1'b0;
    logic prev_drv = 1'b0;
    logic [7:0] model [NREGS];

    always #4 clk = ~clk;

    assign sda_line = host_sda & ~sda_drive_low;

    smbr_target u0 (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .addr_sel      (STRAP),
        .sda_drive_low (sda_drive_low),
        .regs_out      (regs_out)
    );

    // R10 monitor: pull-down must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_drive_low != prev_drv && scl) bad_edges++;
        prev_drv = sda_drive_low;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] nxt(logic [7:0] p);
        return (p >= 8'(NREGS - 1)) ? 8'h00 : p + 8'h01;
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; q_wait();
        scl = 1'b1;      q_wait();
        host_sda = 1'b0; q_wait();
        scl = 1'b0;      q_wait();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; q_wait();
        scl = 1'b1;      q_wait();
        host_sda = 1'b1; q_wait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb, input bit glitch);
        for (int i = 7; i > 7 - nb; i--) begin
            host_sda = b[i]; q_wait();
            scl = 1'b1;      q_wait();
            if (b[i] && !sda_line) low_seen = 1'b1;
            if (glitch && i == 3) begin
                host_sda = 1'b0; @(negedge clk);
                host_sda = 1'b1;
            end
            q_wait();
            scl = 1'b0;      q_wait();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
        send_bits(b, 8, glitch);
        host_sda = 1'b1; q_wait();
        scl = 1'b1;      q_wait();
        ack = ~sda_line; q_wait();
        scl = 1'b0;      q_wait();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_sda = 1'b1; q_wait();
            scl = 1'b1;      q_wait();
            b[i] = sda_line; q_wait();
            scl = 1'b0;      q_wait();
        end
        host_sda = give_ack ? 1'b0 : 1'b1; q_wait();
        scl = 1'b1; q_wait(); q_wait();
        scl = 1'b0; q_wait();
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NREGS; k++)
            check(regs_out[k*8 +: 8] == model[k], req, regs_out[k*8 +: 8], model[k]);
    endtask

    task automatic blk_write(input logic [6:0] addr, input logic [7:0] idx, input logic [7:0] cnt,
                             input int n, input logic [7:0] base, input bit glitch);
        logic       ack;
        logic [7:0] p, d;
        bit         hit;
        hit = (addr == STRAP);
        bus_start();
        send_byte({addr, 1'b0}, 1'b0, ack);
        check(ack == hit, "R2 address ack", ack, hit);
        if (hit) begin
            send_byte(idx, 1'b0, ack); check(ack, "R3 index ack", ack, 1);
            send_byte(cnt, 1'b0, ack); check(ack, "R3 count ack", ack, 1);
            p = idx;
            for (int j = 0; j < n; j++) begin
                d = base + 8'(j * 7);
                if (glitch && j == 0) d[3] = 1'b1;
                send_byte(d, glitch && j == 0, ack);
                if (j < int'(cnt)) begin
                    check(ack, glitch ? "R9 glitch data ack" : "R3 data ack", ack, 1);
                    if (p < 8'(NREGS)) model[p] = d;
                    p = nxt(p);
                end else begin
                    check(!ack, "R4 excess byte nack", ack, 0);
                end
            end
        end
        bus_stop();
        check_bank(hit ? (glitch ? "R9 bank" : "R3 bank") : "R2 bank unchanged");
    endtask

    task automatic blk_read(input logic [7:0] idx, input int n, input bit probe);
        logic       ack;
        logic [7:0] p, b, e;
        bus_start();
        send_byte({STRAP, 1'b0}, 1'b0, ack); check(ack, "R6 write addr ack", ack, 1);
        send_byte(idx, 1'b0, ack);           check(ack, "R6 index ack", ack, 1);
        bus_start();
        send_byte({STRAP, 1'b1}, 1'b0, ack); check(ack, "R6 read addr ack", ack, 1);
        recv_byte(1'b1, b);
        check(b == model[NREGS-1], "R6 count byte", b, model[NREGS-1]);
        p = idx;
        for (int j = 0; j < n; j++) begin
            recv_byte(j < n - 1, b);
            e = (p < 8'(NREGS)) ? model[p] : 8'h00;
            check(b == e, (p == 0 && j > 0) || idx >= 8'(NREGS) ? "R5 read wrap" : "R6 read data", b, e);
            p = nxt(p);
        end
        if (probe) begin
            low_seen = 1'b0;
            send_byte(8'hFF, 1'b0, ack);
            check(!ack && !low_seen, "R7 released after nack", {low_seen, ack}, 0);
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        for (int k = 0; k < NREGS; k++) model[k] = (k == NREGS - 1) ? 8'(NREGS - 1) : 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(sda_drive_low == 1'b0, "R1 sda released", sda_drive_low, 0);
        check_bank("R1 reset values");

        // R3 / R5: every start index, three bytes each (wraps from top)
        for (int i = 0; i < NREGS; i++)
            blk_write(STRAP, 8'(i), 8'd3, 3, 8'(8'h21 + i * 16), 1'b0);
        // R5 out-of-range start index
        blk_write(STRAP, 8'd12, 8'd2, 2, 8'h5C, 1'b0);
        // R4 bytes beyond the count
        blk_write(STRAP, 8'd3, 8'd2, 4, 8'h90, 1'b0);
        // R2 each single-bit address mismatch
        for (int k = 0; k < 7; k++)
            blk_write(STRAP ^ 7'(1 << k), 8'd0, 8'd1, 1, 8'hEE, 1'b0);

        // R6 program read count, then read from every index
        blk_write(STRAP, 8'(NREGS - 1), 8'd1, 1, 8'h05, 1'b0);
        for (int i = 0; i < NREGS; i++) blk_read(8'(i), 4, 1'b0);
        blk_read(8'd11, 2, 1'b0);
        // R7 target ignores clocks after host nack
        blk_read(8'd2, 2, 1'b1);

        // R8 start in the middle of a byte
        bus_start();
        send_byte({STRAP, 1'b0}, 1'b0, ack);
        send_byte(8'd2, 1'b0, ack);
        send_byte(8'd3, 1'b0, ack);
        send_byte(8'hA7, 1'b0, ack);
        model[2] = 8'hA7;
        send_bits(8'h3C, 4, 1'b0);
        bus_start();
        send_byte({STRAP, 1'b0}, 1'b0, ack); check(ack, "R8 restart addr ack", ack, 1);
        send_byte(8'd5, 1'b0, ack);
        send_byte(8'd1, 1'b0, ack);
        send_byte(8'h4B, 1'b0, ack);
        model[5] = 8'h4B;
        bus_stop();
        check_bank("R8 abort keeps writes");

        // R9 one-clock SDA dip while SCL high
        blk_write(STRAP, 8'd6, 8'd2, 2, 8'h18, 1'b1);

        // R10 pull-down edges only with SCL low
        check(bad_edges == 0, "R10 sda edge while scl high", bad_edges, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule